// File: doc/BRIEF.md
# Complex Rotate-Add Unit

This unit reads two 128-bit vector operands as packed complex numbers. Within each pair of adjacent elements, the lower-indexed (even) element is the real part and the next (odd) element is the imaginary part. Before the add, the second operand is turned by a quarter turn in either direction, so each result pair comes from one add and one subtract with the second operand's parts swapped. The element width is 8, 16 or 32 bits and is chosen for each operation.

Each result byte has its own write enable, which comes from upstream predication. A disabled byte takes its value from the old destination contents presented with the operation. The merged result appears in a register one clock after a valid input, together with a valid flag.

Top module: `cplx_rot_add`

## Requirements
- R1: Element i of width W occupies bits [i*W +: W]. Each complex pair uses element 2k as its real part and element 2k+1 as its imaginary part.
- R2: With `rot_270` low (90 degrees), the real result is a.re - b.im and the imaginary result is a.im + b.re.
- R3: With `rot_270` high (270 degrees), the real result is a.re + b.im and the imaginary result is a.im - b.re.
- R4: `elem_size` selects the element width: 0 gives 8 bits, 1 gives 16 bits, 2 gives 32 bits. The value 3 behaves exactly like 2.
- R5: All arithmetic wraps modulo 2^W and does not saturate.
- R6: Bit k of `byte_en` controls result bits [8k +: 8]. When that bit is 1, the byte takes the computed value. When it is 0, the byte takes the same byte of `old_dst`.
- R7: `out_valid` is high in exactly the cycle after a cycle with `in_valid` high, and `result` holds that operation's value in the same cycle.
- R8: In a cycle with `in_valid` low, `result` keeps its previous value, and none of the data inputs affect it.
- R9: After reset, `out_valid` is 0 and `result` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation present this cycle |
| rot_270 | input | 1 | 0: rotate second operand 90 degrees, 1: 270 degrees |
| elem_size | input | 2 | Element width code (0: 8, 1: 16, 2 or 3: 32) |
| op_a | input | 128 | First operand |
| op_b | input | 128 | Second operand, rotated before the add |
| old_dst | input | 128 | Previous destination contents for disabled bytes |
| byte_en | input | 16 | Per-byte write enable |
| out_valid | output | 1 | Result register loaded last cycle |
| result | output | 128 | Registered merged result |

## Verification
Four things are checked by assertions on every cycle. The valid flag is checked to lag the input valid by one cycle. Disabled bytes are checked against the old destination. The result is checked to stay unchanged across idle cycles. With a zero second operand, enabled bytes are checked to equal the first operand. The bench scenarios are what show the arithmetic itself: the correct real and imaginary signs for each rotation, the pairing at each element width, the 32-bit behaviour of the reserved width code, and wraparound at the signed and unsigned limits.

// File: rtl/cplx_rot_add.sv
module cplx_rot_add #(
  parameter int DW = 128
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic          rot_270,
  input  logic [1:0]    elem_size,
  input  logic [DW-1:0] op_a,
  input  logic [DW-1:0] op_b,
  input  logic [DW-1:0] old_dst,
  input  logic [DW/8-1:0] byte_en,
  output logic          out_valid,
  output logic [DW-1:0] result
);
  localparam int NB = DW / 8;
  localparam int NW = 3;

  logic [DW-1:0] sum_w [NW];
  logic [DW-1:0] bmask;
  logic [DW-1:0] sum_sel;
  logic [DW-1:0] merged;

  genvar g, p, k;
  generate
    for (g = 0; g < NW; g++) begin : gw
      localparam int W  = 8 << g;
      localparam int NP = DW / (2 * W);
      for (p = 0; p < NP; p++) begin : gp
        logic [W-1:0] are, aim, bre, bim;
        assign are = op_a[2*p*W +: W];
        assign aim = op_a[(2*p+1)*W +: W];
        assign bre = op_b[2*p*W +: W];
        assign bim = op_b[(2*p+1)*W +: W];
        assign sum_w[g][2*p*W +: W]     = rot_270 ? are + bim : are - bim;
        assign sum_w[g][(2*p+1)*W +: W] = rot_270 ? aim - bre : aim + bre;
      end
    end
    for (k = 0; k < NB; k++) begin : gb
      assign bmask[8*k +: 8] = {8{byte_en[k]}};
    end
  endgenerate

  assign sum_sel = (elem_size == 2'd0) ? sum_w[0] :
                   (elem_size == 2'd1) ? sum_w[1] : sum_w[2];
  assign merged  = (sum_sel & bmask) | (old_dst & ~bmask);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) result <= merged;
    end
  end

  AST_VALID_LAG: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R7
  AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid); // R7
  AST_DISABLED_BYTES: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> ((result ^ $past(old_dst)) & ~$past(bmask)) == '0); // R6
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(result)); // R8
  AST_ZERO_B_IDENTITY: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_b == '0) |=> ((result ^ $past(op_a)) & $past(bmask)) == '0); // R2
endmodule

// File: tb/cplx_rot_add_test.sv
module cplx_rot_add_test;
  logic clk = 0, rst_n = 0, in_valid = 0, rot_270 = 0;
  logic [1:0] elem_size = 0;
  logic [127:0] op_a = 0, op_b = 0, old_dst = 0;
  logic [15:0] byte_en = 0;
  logic out_valid;
  logic [127:0] result;

  int compared = 0, mismatched = 0;
  logic exp_valid = 0;
  logic [127:0] exp_result = 0;

  always #10 clk = ~clk;

  cplx_rot_add uut (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .rot_270(rot_270),
    .elem_size(elem_size), .op_a(op_a), .op_b(op_b), .old_dst(old_dst),
    .byte_en(byte_en), .out_valid(out_valid), .result(result));

  function automatic logic [127:0] model(logic [127:0] a, logic [127:0] b,
      logic [127:0] old, logic [15:0] en, logic rot, logic [1:0] es);
    int w = (es == 0) ? 8 : (es == 1) ? 16 : 32;
    longint mask = (longint'(1) << w) - 1;
    logic [127:0] r = 0, out;
    for (int p = 0; p < 128 / (2 * w); p++) begin
      longint ar = longint'((a >> (2*p*w)) & 128'(mask));
      longint ai = longint'((a >> ((2*p+1)*w)) & 128'(mask));
      longint br = longint'((b >> (2*p*w)) & 128'(mask));
      longint bi = longint'((b >> ((2*p+1)*w)) & 128'(mask));
      longint re = rot ? ar + bi : ar - bi;
      longint im = rot ? ai - br : ai + br;
      r |= 128'(re & mask) << (2*p*w);
      r |= 128'(im & mask) << ((2*p+1)*w);
    end
    for (int k = 0; k < 16; k++)
      out[8*k +: 8] = en[k] ? r[8*k +: 8] : old[8*k +: 8];
    return out;
  endfunction

  task automatic compare(string tag);
    compared++;
    if (out_valid !== exp_valid || result !== exp_result) begin
      mismatched++;
      $display("FAIL %s: valid=%0b result=%h expected valid=%0b result=%h",
               tag, out_valid, result, exp_valid, exp_result);
    end
  endtask

  task automatic cycle(string tag, logic v, logic rot, logic [1:0] es,
      logic [127:0] a, logic [127:0] b, logic [127:0] old, logic [15:0] en);
    in_valid = v; rot_270 = rot; elem_size = es;
    op_a = a; op_b = b; old_dst = old; byte_en = en;
    @(posedge clk);
    exp_valid = v;
    if (v) exp_result = model(a, b, old, en, rot, es);
    @(negedge clk);
    compare(tag);
  endtask

  initial begin
    #2000000;
    mismatched++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    compare("R9");
    rst_n = 1;
    // R2: 16-bit pairs, 90 degrees
    cycle("R2", 1, 0, 1, 128'h0004_0003_0002_0001_0010_0020_0030_0040,
          128'h0001_0001_0005_0007_0002_0003_0004_0005, '0, 16'hFFFF);
    // R3: 8-bit pairs, 270 degrees
    cycle("R3", 1, 1, 0, 128'h0102030405060708090A0B0C0D0E0F10,
          128'h11223344556677880011223344556677, '0, 16'hFFFF);
    // R1: single pair position check, 32-bit
    cycle("R1", 1, 0, 2, 128'h0000000A_00000005, 128'h00000003_00000002, '0, 16'hFFFF);
    // R4: reserved code behaves as 32-bit
    cycle("R4", 1, 1, 3, 128'h12345678_9ABCDEF0_0F0F0F0F_F0F0F0F0,
          128'h11111111_22222222_33333333_44444444, '0, 16'hFFFF);
    // R5: wraparound at limits
    cycle("R5", 1, 0, 0, {8{16'h7F80}}, {8{16'hFF01}}, '0, 16'hFFFF);
    cycle("R5", 1, 1, 2, {4{32'hFFFFFFFF}}, {4{32'h80000001}}, '0, 16'hFFFF);
    // R6: byte enables with old destination
    cycle("R6", 1, 0, 1, {8{16'h1234}}, {8{16'h0101}}, {16{8'hA5}}, 16'h5A3C);
    cycle("R6", 1, 1, 0, {16{8'h33}}, {16{8'h11}}, {16{8'hEE}}, 16'h0000);
    // R7/R8: idle cycles hold result, inputs ignored
    cycle("R8", 0, 1, 0, {16{8'hFF}}, {16{8'hFF}}, {16{8'h00}}, 16'hFFFF);
    cycle("R8", 0, 0, 2, '1, '0, '1, 16'h1234);
    cycle("R7", 1, 0, 2, '0, '0, {16{8'h5C}}, 16'h00F0);
    for (int i = 0; i < 300; i++) begin
      cycle("R7", ($urandom % 4) != 0, $urandom % 2, 2'($urandom % 4),
            {$urandom, $urandom, $urandom, $urandom},
            {$urandom, $urandom, $urandom, $urandom},
            {$urandom, $urandom, $urandom, $urandom}, 16'($urandom));
    end
    rst_n = 0;
    @(posedge clk); exp_valid = 0; exp_result = 0;
    @(negedge clk); compare("R9");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule